// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home node of a distributed shared-memory multiprocessor. It holds, for every memory block it owns, a coherence state and a presence vector with one bit per processor. It takes point-to-point request messages from the processors: read miss, write miss and data write-back. For each request it sends the messages needed to keep the caches coherent, and then one reply to the requester. Because sharers are tracked per block, invalidations go only to the processors that hold a copy. Nothing is broadcast.

Requests arrive in order, one message per handshake. Each processor stalls until its own access completes. The controller works on one request at a time and holds `req_ready` low until the reply for the current request has left. Outgoing messages leave one per cycle. They are invalidations, fetches to an owner and replies. When a fetch is sent, the controller waits for the owner's data on the fetch-return input. It writes that data to memory and passes it on. Block data is kept in a small internal array, which is written by a one-cycle update strobe.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and all memory words are zero. `req_ready` is 1 and `out_valid` is 0.
- R2: A read miss (`req_kind`=0) on an Uncached or Shared block produces a reply of kind 0 (data) to the requester, carrying the memory word. The block becomes Shared and the requester's bit is added.
- R3: A write miss (`req_kind`=1) on an Uncached block produces a data reply with the memory word. The requester becomes the sole owner and the block becomes Exclusive.
- R4: A write miss on a Shared block sends an invalidate (kind 1) to every sharer other than the requester, in ascending processor index. A data reply then follows. The block becomes Exclusive with the requester as the only bit set. If the requester is the only sharer, no invalidate is sent.
- R5: A read miss on an Exclusive block sends a fetch (kind 2) to the owner. The data returned on `fet_data` is written to memory and sent to the requester. The block becomes Shared with both the owner bit and the requester bit set.
- R6: A write miss on an Exclusive block sends a fetch-and-invalidate (kind 3) to the owner. The returned data goes to the requester, which becomes the sole owner. The block stays Exclusive.
- R7: A write-back (`req_kind`=2) writes `req_data` to memory. It is answered with an acknowledge (kind 4) that echoes the written word. The block becomes Uncached with an empty vector.
- R8: Once a request is accepted, `req_ready` stays 0 until the cycle after its reply. This includes the whole wait for fetch data. A request presented during that time is accepted later and is not lost.
- R9: Every request gets exactly one reply (kind 0 or 4) addressed to its source. `out_blk` always names the block of the request being served.
- R10: An Exclusive block always has exactly one presence bit set. An Uncached block has none. A Shared block has at least one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request message is offered |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_src | input | clog2(NP) | Requesting processor |
| req_blk | input | clog2(NB) | Block index |
| req_data | input | DW | Write-back data |
| fet_valid | input | 1 | Owner returns data for an outstanding fetch |
| fet_data | input | DW | Data returned by the owner |
| out_valid | output | 1 | An outgoing message is present this cycle |
| out_kind | output | 3 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 write-back acknowledge |
| out_dst | output | clog2(NP) | Destination processor |
| out_blk | output | clog2(NB) | Block the message concerns |
| out_data | output | DW | Data for kinds 0 and 4, zero otherwise |

## Verification
Two events can coincide. One is the owner's fetch data arriving. The other is a new request already waiting at the input. The bench provokes this by presenting the next request while a fetch is still outstanding. During the wait it judges that `req_ready` stays low on each cycle. It then checks that the waiting request is served only after the reply that the fetch data completes. A write miss to a block with several sharers also puts a burst of invalidates back to back with the reply. The scoreboard checks that burst in order.

// File: rtl/coh_pkg.sv
// Shared constants and types for the home-node directory controller.
// Assumes message kind and state encodings are fixed across the code base.
package coh_pkg;
    localparam logic [1:0] DIR_UNC = 2'd0;
    localparam logic [1:0] DIR_SHR = 2'd1;
    localparam logic [1:0] DIR_EXC = 2'd2;

    localparam logic [1:0] REQ_RD = 2'd0;
    localparam logic [1:0] REQ_WR = 2'd1;
    localparam logic [1:0] REQ_WB = 2'd2;

    localparam logic [2:0] MSG_DATA      = 3'd0;
    localparam logic [2:0] MSG_INV       = 3'd1;
    localparam logic [2:0] MSG_FETCH     = 3'd2;
    localparam logic [2:0] MSG_FETCH_INV = 3'd3;
    localparam logic [2:0] MSG_WB_ACK    = 3'd4;

    typedef enum logic [2:0] {
        C_IDLE, C_LOOK, C_INV, C_FETCH, C_WAIT, C_REPLY
    } ctl_e;
endpackage

// File: rtl/first_one.sv
// Finds the lowest set bit of a mask.
// Assumes the caller checks 'found' before using 'idx'.
module first_one #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          found
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dir_table.sv
// Per-block directory storage: a 2-bit state and a presence vector.
// One combinational read port and one synchronous write port.
// Assumes a single writer per cycle.
module dir_table
    import coh_pkg::*;
#(
    parameter int NP = 4,
    parameter int NB = 16,
    parameter int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] rd_blk,
    output logic [1:0]    rd_state,
    output logic [NP-1:0] rd_vec,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_blk,
    input  logic [1:0]    wr_state,
    input  logic [NP-1:0] wr_vec
);
    logic [1:0]    st_q  [NB];
    logic [NP-1:0] vec_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_ent
        // hold or update one directory entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= DIR_UNC;
                vec_q[g] <= '0;
            end else if (wr_en && wr_blk == BW'(g)) begin
                st_q[g]  <= wr_state;
                vec_q[g] <= wr_vec;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_vec   = vec_q[rd_blk];

    // R10
    exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DIR_EXC) |-> ($countones(rd_vec) == 1))
        else $error("exclusive entry without a single owner");
    // R10
    unc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DIR_UNC) |-> (rd_vec == '0))
        else $error("uncached entry with sharers");
    // R10
    shr_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == DIR_SHR) |-> (rd_vec != '0))
        else $error("shared entry with no sharers");
endmodule

// File: rtl/data_store.sv
// Block data array with one combinational read and an update strobe.
// Assumes memory starts at zero after reset.
module data_store #(
    parameter int NB = 16,
    parameter int DW = 32,
    parameter int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] rd_blk,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_blk,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_word
        // hold or update one data word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (wr_en && wr_blk == BW'(g))
                mem_q[g] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_blk];
endmodule

// File: rtl/home_dir_ctrl.sv
// Home-node coherence directory controller.
// Serves read miss, write miss and write-back requests one at a time.
// Emits invalidates, fetches and one reply per request, one message per cycle.
// Assumes in-order delivery and that fet_valid comes only while a fetch is outstanding.
module home_dir_ctrl
    import coh_pkg::*;
#(
    parameter int NP = 4,
    parameter int NB = 16,
    parameter int DW = 32,
    localparam int SW = (NP > 1) ? $clog2(NP) : 1,
    localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [SW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    input  logic          fet_valid,
    input  logic [DW-1:0] fet_data,
    output logic          out_valid,
    output logic [2:0]    out_kind,
    output logic [SW-1:0] out_dst,
    output logic [BW-1:0] out_blk,
    output logic [DW-1:0] out_data
);
    ctl_e          state_q;
    logic [1:0]    kind_q;
    logic [SW-1:0] src_q;
    logic [BW-1:0] blk_q;
    logic [DW-1:0] data_q;
    logic [NP-1:0] pend_q;
    logic [SW-1:0] owner_q;
    logic [2:0]    fet_kind_q;
    logic [2:0]    rep_kind_q;
    logic [1:0]    upd_st_q;
    logic [NP-1:0] upd_vec_q;

    logic [1:0]    rd_st;
    logic [NP-1:0] rd_vec;
    logic [DW-1:0] mem_rd;
    logic          dir_we, mem_we;
    logic [1:0]    dir_ws;
    logic [NP-1:0] dir_wv;
    logic [DW-1:0] mem_wd;
    logic [SW-1:0] inv_idx, own_idx;
    logic          inv_found, own_found;
    logic [NP-1:0] src_hot, inv_hot, others;

    assign src_hot = NP'(1) << src_q;
    assign inv_hot = NP'(1) << inv_idx;
    assign others  = rd_vec & ~src_hot;

    dir_table #(.NP(NP), .NB(NB)) i_dir (
        .clk(clk), .rst_n(rst_n), .rd_blk(blk_q), .rd_state(rd_st), .rd_vec(rd_vec),
        .wr_en(dir_we), .wr_blk(blk_q), .wr_state(dir_ws), .wr_vec(dir_wv)
    );

    data_store #(.NB(NB), .DW(DW)) i_mem (
        .clk(clk), .rst_n(rst_n), .rd_blk(blk_q), .rd_data(mem_rd),
        .wr_en(mem_we), .wr_blk(blk_q), .wr_data(mem_wd)
    );

    first_one #(.W(NP), .IW(SW)) i_inv_pick (.mask(pend_q), .idx(inv_idx), .found(inv_found));
    first_one #(.W(NP), .IW(SW)) i_own_pick (.mask(rd_vec), .idx(own_idx), .found(own_found));

    // directory and memory writes for the current step
    always_comb begin
        dir_we = 1'b0;
        dir_ws = DIR_UNC;
        dir_wv = '0;
        mem_we = 1'b0;
        mem_wd = data_q;
        case (state_q)
            C_LOOK: begin
                if (kind_q == REQ_WB) begin
                    dir_we = 1'b1;
                    mem_we = 1'b1;
                end else if (rd_st != DIR_EXC) begin
                    dir_we = 1'b1;
                    dir_ws = (kind_q == REQ_RD) ? DIR_SHR : DIR_EXC;
                    dir_wv = (kind_q == REQ_RD) ? (rd_vec | src_hot) : src_hot;
                end
            end
            C_WAIT: begin
                if (fet_valid) begin
                    dir_we = 1'b1;
                    dir_ws = upd_st_q;
                    dir_wv = upd_vec_q;
                    mem_we = 1'b1;
                    mem_wd = fet_data;
                end
            end
            default: ;
        endcase
    end

    // request sequencing and message registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= C_IDLE;
            kind_q     <= REQ_RD;
            src_q      <= '0;
            blk_q      <= '0;
            data_q     <= '0;
            pend_q     <= '0;
            owner_q    <= '0;
            fet_kind_q <= MSG_FETCH;
            rep_kind_q <= MSG_DATA;
            upd_st_q   <= DIR_UNC;
            upd_vec_q  <= '0;
        end else begin
            case (state_q)
                C_IDLE: begin
                    if (req_valid) begin
                        kind_q  <= req_kind;
                        src_q   <= req_src;
                        blk_q   <= req_blk;
                        data_q  <= req_data;
                        state_q <= C_LOOK;
                    end
                end
                C_LOOK: begin
                    if (kind_q == REQ_WB) begin
                        rep_kind_q <= MSG_WB_ACK;
                        state_q    <= C_REPLY;
                    end else begin
                        rep_kind_q <= MSG_DATA;
                        if (rd_st == DIR_EXC) begin
                            owner_q    <= own_idx;
                            fet_kind_q <= (kind_q == REQ_RD) ? MSG_FETCH : MSG_FETCH_INV;
                            upd_st_q   <= (kind_q == REQ_RD) ? DIR_SHR : DIR_EXC;
                            upd_vec_q  <= (kind_q == REQ_RD) ? (rd_vec | src_hot) : src_hot;
                            state_q    <= C_FETCH;
                        end else begin
                            data_q <= mem_rd;
                            if (kind_q == REQ_WR && rd_st == DIR_SHR && others != '0) begin
                                pend_q  <= others;
                                state_q <= C_INV;
                            end else begin
                                state_q <= C_REPLY;
                            end
                        end
                    end
                end
                C_INV: begin
                    pend_q <= pend_q & ~inv_hot;
                    if ((pend_q & ~inv_hot) == '0)
                        state_q <= C_REPLY;
                end
                C_FETCH: state_q <= C_WAIT;
                C_WAIT: begin
                    if (fet_valid) begin
                        data_q  <= fet_data;
                        state_q <= C_REPLY;
                    end
                end
                C_REPLY: state_q <= C_IDLE;
                default: state_q <= C_IDLE;
            endcase
        end
    end

    // outgoing message selection
    always_comb begin
        out_valid = 1'b0;
        out_kind  = MSG_DATA;
        out_dst   = src_q;
        out_data  = '0;
        case (state_q)
            C_INV: begin
                out_valid = 1'b1;
                out_kind  = MSG_INV;
                out_dst   = inv_idx;
            end
            C_FETCH: begin
                out_valid = 1'b1;
                out_kind  = fet_kind_q;
                out_dst   = owner_q;
            end
            C_REPLY: begin
                out_valid = 1'b1;
                out_kind  = rep_kind_q;
                out_data  = data_q;
            end
            default: ;
        endcase
    end

    assign out_blk   = blk_q;
    assign req_ready = (state_q == C_IDLE);

    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready)
        else $error("accepted a second request back to back");
    // R8
    wait_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == MSG_FETCH || out_kind == MSG_FETCH_INV)) |=> !req_ready)
        else $error("ready while a fetch is outstanding");
    // R9
    reply_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == MSG_DATA || out_kind == MSG_WB_ACK)) |=> req_ready)
        else $error("not released after the reply");
    // R4
    inv_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == MSG_INV) |-> (out_dst != src_q && inv_found))
        else $error("invalidate aimed at the requester");
    // R5
    fetch_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_LOOK && kind_q != REQ_WB && rd_st == DIR_EXC) |-> own_found)
        else $error("exclusive block without an owner");
endmodule

// File: tb/test_home_dir_ctrl.sv
`timescale 1ns/1ps
module test_home_dir_ctrl;
    localparam int NP = 4;
    localparam int NB = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [1:0]    req_src = '0;
    logic [3:0]    req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          fet_valid = 1'b0;
    logic [DW-1:0] fet_data = '0;
    logic          out_valid;
    logic [2:0]    out_kind;
    logic [1:0]    out_dst;
    logic [3:0]    out_blk;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0]  k;
        logic [1:0]  d;
        logic [3:0]  b;
        logic [31:0] v;
    } exp_t;
    exp_t exp_q[$];
    int   tag_q[$];

    // independent model of the directory and memory
    logic [1:0]    m_st  [NB];
    logic [NP-1:0] m_vec [NB];
    logic [DW-1:0] m_mem [NB];

    always #2 clk = ~clk;

    home_dir_ctrl #(.NP(NP), .NB(NB), .DW(DW)) i_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_src(req_src), .req_blk(req_blk), .req_data(req_data),
        .fet_valid(fet_valid), .fet_data(fet_data), .out_valid(out_valid),
        .out_kind(out_kind), .out_dst(out_dst), .out_blk(out_blk), .out_data(out_data)
    );

    function automatic logic [31:0] fv(input logic [1:0] own, input logic [3:0] blk);
        return 32'hC0DE_0000 + 32'(own) * 256 + 32'(blk);
    endfunction

    function automatic logic [1:0] low_bit(input logic [NP-1:0] v);
        for (int i = 0; i < NP; i++) if (v[i]) return 2'(i);
        return 2'd0;
    endfunction

    task automatic push(input logic [2:0] k, input logic [1:0] d, input logic [3:0] b,
                        input logic [31:0] v, input int tag);
        exp_q.push_back('{k: k, d: d, b: b, v: v});
        tag_q.push_back(tag);
    endtask

    // driver: update the model, queue the expected messages, then hand the request over
    task automatic send(input logic [1:0] k, input logic [1:0] s, input logic [3:0] b,
                        input logic [31:0] v, input int tag);
        logic [NP-1:0] hot;
        logic [1:0]    own;
        hot = NP'(1) << s;
        if (k == 2'd2) begin                     // R7
            m_mem[b] = v;
            push(3'd4, s, b, v, tag);
            m_st[b] = 2'd0; m_vec[b] = '0;
        end else if (m_st[b] == 2'd2) begin      // R5 / R6
            own = low_bit(m_vec[b]);
            push((k == 2'd0) ? 3'd2 : 3'd3, own, b, 32'd0, tag);
            m_mem[b] = fv(own, b);
            push(3'd0, s, b, m_mem[b], tag);
            if (k == 2'd0) begin m_st[b] = 2'd1; m_vec[b] = m_vec[b] | hot; end
            else           begin m_vec[b] = hot; end
        end else if (k == 2'd0) begin            // R2
            push(3'd0, s, b, m_mem[b], tag);
            m_st[b] = 2'd1; m_vec[b] = m_vec[b] | hot;
        end else begin                           // R3 / R4
            if (m_st[b] == 2'd1)
                for (int i = 0; i < NP; i++)
                    if (m_vec[b][i] && i != int'(s)) push(3'd1, 2'(i), b, 32'd0, tag);
            push(3'd0, s, b, m_mem[b], tag);
            m_st[b] = 2'd2; m_vec[b] = hot;
        end
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = s; req_blk = b; req_data = v;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: pop and compare each message the design emits
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected message kind=%0d dst=%0d blk=%0d expected none",
                         out_kind, out_dst, out_blk);
            end else begin
                exp_t e;
                int   t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_kind != e.k || out_dst != e.d || out_blk != e.b ||
                    ((e.k == 3'd0 || e.k == 3'd4) && out_data != e.v)) begin
                    errors++;
                    $display("FAIL R%0d got kind=%0d dst=%0d blk=%0d data=%h expected kind=%0d dst=%0d blk=%0d data=%h",
                             t, out_kind, out_dst, out_blk, out_data, e.k, e.d, e.b, e.v);
                end
            end
        end
    end

    // owner model: answer fetches after a delay and check the hold-off (R8)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && (out_kind == 3'd2 || out_kind == 3'd3)) begin
                logic [1:0] d;
                logic [3:0] b;
                d = out_dst; b = out_blk;
                for (int n = 0; n < 3; n++) begin
                    @(negedge clk);
                    checks++;
                    if (req_ready !== 1'b0) begin
                        errors++;
                        $display("FAIL R8 req_ready=%b during fetch wait expected 0", req_ready);
                    end
                end
                fet_valid = 1'b1; fet_data = fv(d, b);
                @(negedge clk);
                fet_valid = 1'b0;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired with %0d messages pending", exp_q.size());
        finish_run();
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_st[i] = 2'd0; m_vec[i] = '0; m_mem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (req_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 ready=%b valid=%b expected 1 0", req_ready, out_valid);
        end
        send(2'd0, 2'd0, 4'd3, 32'd0, 1);          // R1 zero memory, R2 read on Uncached
        send(2'd0, 2'd1, 4'd3, 32'd0, 2);          // R2 read on Shared
        send(2'd0, 2'd2, 4'd3, 32'd0, 2);          // R2
        send(2'd1, 2'd1, 4'd3, 32'd0, 4);          // R4 invalidates p0 then p2
        send(2'd0, 2'd3, 4'd3, 32'd0, 5);          // R5 fetch from p1
        send(2'd1, 2'd0, 4'd5, 32'd0, 3);          // R3 write on Uncached
        send(2'd1, 2'd2, 4'd5, 32'd0, 6);          // R6 fetch-and-invalidate p0
        send(2'd2, 2'd2, 4'd5, 32'h1234_5678, 7);  // R7 write-back
        send(2'd0, 2'd1, 4'd5, 32'd0, 10);         // R10 Uncached after write-back: no fetch
        send(2'd1, 2'd1, 4'd5, 32'd0, 4);          // R4 sole sharer: no invalidate
        send(2'd1, 2'd3, 4'd3, 32'd0, 4);          // R4 invalidate p1, data from R5 memory update
        send(2'd0, 2'd0, 4'd5, 32'd0, 8);          // R8 fetch outstanding ...
        send(2'd0, 2'd2, 4'd7, 32'd0, 8);          // R8 ... while this one waits
        send(2'd2, 2'd3, 4'd3, 32'h0000_A5A5, 7);  // R7
        send(2'd1, 2'd0, 4'd3, 32'd0, 9);          // R9 reply with written-back word
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule